// File: doc/BRIEF.md
# Floating-point exception status and control register

This block keeps the status and control word that sits beside a floating-point unit. It holds a rounding-mode selection, a mask of enabled exceptions, a cause field that describes only the most recent operation, and sticky flag bits that accumulate every exception until software clears them. Software reads and writes the whole word through a simple 32-bit port.

The FPU datapath pulses `op_start_i` when it begins each operation. It drives `exc_i` with the exceptions that operation raises. The block decodes the stored rounding code for the datapath. It raises `trap_o` while any recorded cause is enabled, or while the non-maskable FPU-error cause is set. The vectoring logic uses `trap_o` to take the exception.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset every field is zero, `rd_data_o` reads 0, `trap_o` is 0 and `rnd_zero_o` is 0.
- R2: The register word has a fixed layout. Bits 1:0 hold the rounding code, bits 6:2 the flags, bits 11:7 the enables and bits 17:12 the cause. A write stores each field, and `rd_data_o` returns it on the next cycle. Bits 31:18 always read 0.
- R3: When `op_start_i` is high, the cause field is zero on the next cycle, apart from bits set by `exc_i` in the same cycle. This also overrides a software write to the cause field in that cycle.
- R4: `exc_i` bit i sets cause bit i (bit 12+i of the word) on the next cycle. For i in 0..4 it also sets flag bit i (bit 2+i). The bits mean 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid and 5 FPU error. Bit 5 has no flag.
- R5: When `op_start_i` and an `exc_i` bit arrive in the same cycle, that cause bit ends at 1.
- R6: A flag bit set to 1 stays at 1 through operation starts and exception-free cycles. Only a software write with that bit at 0 clears it.
- R7: When a software write and `exc_i` fall in the same cycle, the stored flags equal the written flag value ORed with `exc_i[4:0]`.
- R8: `trap_o` is high exactly when some cause bit i in 0..4 and enable bit i are both 1, or when cause bit 5 is 1.
- R9: Rounding codes 00, 01, 10 and 11 are stored and read back as written. `rnd_zero_o` is 0 for code 00 (round to nearest) and 1 for all other codes (round to zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Register readback |
| op_start_i | input | 1 | Pulses at the start of each FPU operation |
| exc_i | input | 6 | Exception events, one bit per exception |
| rnd_zero_o | output | 1 | 1 selects round to zero, 0 selects round to nearest |
| trap_o | output | 1 | Exception trap request |

## Verification
The hardest situations to reach involve collisions. A software write, an operation start and exception events can all land in the same cycle, and each of them pulls the cause and flag fields a different way. Directed steps drive every pairing and the triple collision with known values. A long random phase then biases each strobe to be active often, so the collisions recur with varied masks and enables. Every cycle's readback, trap and rounding output is compared with a bench model built from the requirements.

// File: rtl/fpu_status_pkg.sv
package fpu_status_pkg;
  localparam int DATA_W    = 32;
  localparam int EXC_W     = 5;
  localparam int CAUSE_W   = EXC_W + 1;
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + EXC_W;
  localparam int CAUSE_LSB = EN_LSB + EXC_W;
  localparam int CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_RSVD_A  = 2'b10,
    RM_RSVD_B  = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpu_cause_reg.sv
module fpu_cause_reg
  import fpu_status_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         op_start_i,
  input  logic [W-1:0] exc_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, base, cause_d;

  // priority: sw write < op clear < new event
  always_comb begin
    base = wr_en_i ? wr_val_i : cause_q;
    if (op_start_i) base = '0;
    cause_d = base | exc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  AST_OP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_i && exc_i == '0) |=> cause_q == '0); // R3
  AST_EXC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i != '0) |=> (cause_q & $past(exc_i)) == $past(exc_i)); // R5
endmodule

// File: rtl/fpu_flag_reg.sv
module fpu_flag_reg
  import fpu_status_pkg::*;
#(
  parameter int W = EXC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_val_i,
  input  logic [W-1:0] exc_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= (wr_en_i ? wr_val_i[i] : flag_q[i]) | exc_i[i];
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R6
  AST_FLAG_WR_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> flag_q == ($past(wr_val_i) | $past(exc_i))); // R7
endmodule

// File: rtl/fpu_round_dec.sv
module fpu_round_dec
  import fpu_status_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [RM_W-1:0] wr_val_i,
  output logic [RM_W-1:0] rm_o,
  output logic            rnd_zero_o
);
  rmode_e rm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rm_q <= RM_NEAREST;
    else if (wr_en_i) rm_q <= rmode_e'(wr_val_i);
  end

  assign rm_o = rm_q;
  // reserved codes behave as round to zero
  assign rnd_zero_o = (rm_q != RM_NEAREST);

  AST_RM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rm_o)); // R9
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fpu_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              op_start_i,
  input  logic [CAUSE_W-1:0] exc_i,
  output logic              rnd_zero_o,
  output logic              trap_o
);
  logic [CAUSE_W-1:0] cause;
  logic [EXC_W-1:0]   flag, en_q;
  logic [RM_W-1:0]    rm;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:CAUSE_MSB+1];

  fpu_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_val_i  (wr_data_i[CAUSE_MSB:CAUSE_LSB]),
    .op_start_i,
    .exc_i,
    .cause_o   (cause)
  );

  fpu_flag_reg #(.W(EXC_W)) u_flag (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_val_i (wr_data_i[FLAG_LSB+EXC_W-1:FLAG_LSB]),
    .exc_i    (exc_i[EXC_W-1:0]),
    .flag_o   (flag)
  );

  fpu_round_dec u_rm (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_val_i   (wr_data_i[RM_LSB+RM_W-1:RM_LSB]),
    .rm_o       (rm),
    .rnd_zero_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= wr_data_i[EN_LSB+EXC_W-1:EN_LSB];
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[CAUSE_MSB:CAUSE_LSB]         = cause;
    rd_data_o[EN_LSB+EXC_W-1:EN_LSB]       = en_q;
    rd_data_o[FLAG_LSB+EXC_W-1:FLAG_LSB]   = flag;
    rd_data_o[RM_LSB+RM_W-1:RM_LSB]        = rm;
  end

  // FPU-error cause is non-maskable
  assign trap_o = (|(cause[EXC_W-1:0] & en_q)) | cause[CAUSE_W-1];

  AST_ERR_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i[CAUSE_W-1]) |=> trap_o); // R8
  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:CAUSE_MSB+1] == '0); // R2
endmodule

// File: tb/fpu_status_reg_tb.sv
module fpu_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_start = 1'b0;
  logic [5:0]  exc = '0;
  logic [31:0] rd_data;
  logic        rnd_zero, trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] m_cause;
  logic [4:0] m_en, m_flag;
  logic [1:0] m_rm;

  always #10 clk = ~clk;

  fpu_status_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .op_start_i(op_start), .exc_i(exc),
    .rnd_zero_o(rnd_zero), .trap_o(trap)
  );

  function automatic logic [31:0] exp_word();
    return {14'b0, m_cause, m_en, m_flag, m_rm};
  endfunction

  function automatic logic exp_trap();
    return (|(m_cause[4:0] & m_en)) | m_cause[5];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " word"}, rd_data, exp_word());
    chk("R8 trap", {31'b0, trap}, {31'b0, exp_trap()});
    chk("R9 rnd_zero", {31'b0, rnd_zero}, {31'b0, (m_rm != 2'b00)});
  endtask

  // model update per requirement R3..R9
  task automatic step(input logic w, input logic [31:0] wd, input logic op,
                      input logic [5:0] e, input string tag);
    @(negedge clk);
    wr_en = w; wr_data = wd; op_start = op; exc = e;
    @(posedge clk);
    begin
      logic [5:0] cb;
      cb = w ? wd[17:12] : m_cause;
      if (op) cb = '0;
      m_cause = cb | e;
      m_flag  = (w ? wd[6:2] : m_flag) | e[4:0];
      if (w) begin
        m_en = wd[11:7];
        m_rm = wd[1:0];
      end
    end
    #5;
    wr_en = 1'b0; op_start = 1'b0; exc = '0;
    check_all(tag);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] c, input logic [4:0] en,
                                     input logic [4:0] f, input logic [1:0] rm);
    return {14'h3fff, c, en, f, rm}; // high bits set to prove they read 0
  endfunction

  initial begin
    m_cause = '0; m_en = '0; m_flag = '0; m_rm = '0;
    #35;
    check_all("R1 in reset");
    rst_n = 1'b1;
    #20;
    check_all("R1 after reset");

    step(1, mk(6'h2a, 5'h15, 5'h0a, 2'b01), 0, 6'h00, "R2 layout write");
    step(1, mk(6'h15, 5'h0a, 5'h15, 2'b10), 0, 6'h00, "R9 rsvd code 10");
    step(1, mk(6'h00, 5'h00, 5'h00, 2'b11), 0, 6'h00, "R9 rsvd code 11");
    step(1, mk(6'h00, 5'h00, 5'h00, 2'b00), 0, 6'h00, "R9 nearest");
    step(0, 32'h0, 0, 6'h04, "R4 overflow sets cause+flag");
    step(0, 32'h0, 1, 6'h00, "R3 op clears cause");
    step(0, 32'h0, 0, 6'h00, "R6 flag held");
    step(0, 32'h0, 1, 6'h11, "R5 op with event");
    step(0, 32'h0, 0, 6'h20, "R4 error bit no flag");
    step(0, 32'h0, 1, 6'h00, "R3 clear error cause");
    step(1, mk(6'h3f, 5'h08, 5'h00, 2'b00), 1, 6'h00, "R3 op overrides write");
    step(1, mk(6'h00, 5'h04, 5'h01, 2'b00), 0, 6'h06, "R7 write merges events");
    step(1, mk(6'h00, 5'h00, 5'h00, 2'b00), 0, 6'h00, "R6 sw clears flags");
    step(1, mk(6'h08, 5'h08, 5'h00, 2'b00), 0, 6'h00, "R8 enabled cause traps");
    step(1, mk(6'h08, 5'h10, 5'h00, 2'b00), 0, 6'h00, "R8 masked no trap");
    step(1, mk(6'h20, 5'h00, 5'h00, 2'b00), 0, 6'h00, "R8 error unmasked");
    step(1, mk(6'h3f, 5'h1f, 5'h1f, 2'b11), 1, 6'h01, "R3 triple collision");

    void'($urandom(1234));
    for (int i = 0; i < 600; i++) begin
      logic w, op;
      logic [5:0] e;
      logic [31:0] d;
      w  = ($urandom % 4) == 0;
      op = ($urandom % 3) == 0;
      e  = (($urandom % 3) == 0) ? 6'($urandom) : 6'h00;
      d  = $urandom;
      step(w, d, op, e, "R4 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule